// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block watches the command bus of a four-bank SDRAM and reports every command that breaks a timing or ordering rule. Each rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable levels, together with the clock-enable level, the bank select and the auto-close address bit. It keeps a record for each bank: whether the bank is open, whether an auto-close burst is still running, and how many cycles have passed since the last activate, the last read or write, and the last close. A single global counter measures the time since the last refresh.

All timing limits are parameters counted in clock cycles. Every counter saturates, so a counter that has been idle for a long time still reads as "long ago". When a rule is broken, the block raises a one-cycle violation pulse together with a rule code and the index of the offending bank. The violation is registered, so it appears in the cycle after the edge that sampled the command. The block only observes the bus and never drives it. It is meant to sit beside a memory controller in simulation or on silicon as a protocol monitor.

Top module: `sdram_timing_guard`

## Requirements
- R1: After reset no bank is open, `violValid` is low, and every per-bank counter reads as saturated. A violation appears as `violValid` high for exactly one cycle, in the cycle after the edge that sampled the command, with `violRule` and `violBank` valid in that cycle. A command with no broken rule gives no pulse.
- R2: Command pins are decoded only when `csN` is low and `cke` is high, as {rasN,casN,weN}: 011 activate, 010 precharge, 101 read, 100 write. An activate to a bank that is already open gives code 1.
- R3: An activate to a bank fewer than T_RC cycles after that bank's previous activate gives code 2.
- R4: An activate fewer than T_RRD cycles after an activate to any other bank gives code 3, reported against the bank being activated.
- R5: An activate gives code 4 in either of two cases: it comes fewer than T_RP cycles after an explicit precharge closed that bank, or it comes fewer than BURST_LEN+T_RP cycles after a read or write with auto-close to that bank.
- R6: A read or write gives code 5 when it comes fewer than T_RCD cycles after the bank's activate. A read or write to a bank that is not open gives code 6.
- R7: A precharge with `a10` high closes every open bank. A precharge with `a10` low closes only the bank on `bankSel`. The `bankOpen` output shows the result in the cycle after the command.
- R8: A read or write with `a10` high closes its bank at once and starts an auto-close burst of BURST_LEN cycles. A read, write or precharge that reaches that bank fewer than BURST_LEN cycles after the command gives code 7. This code takes precedence over code 6.
- R9: When FULL_PAGE is set, any read or write with `a10` high to an open bank gives code 8.
- R10: A precharge fewer than T_RAS_MIN cycles after the bank's activate gives code 9. A bank that is still open T_RAS_MAX cycles after its activate gives code 10 once, in the cycle after that count is reached.
- R11: Pin code 001 with `csN` low is a refresh. With `cke` high it is an auto refresh; with `cke` low it is a self-refresh entry. Either form gives code 11 if any bank is open or in an auto-close burst, reported against the lowest such bank.
- R12: If T_REFI cycles pass since the last refresh (or since reset) without a new refresh, the block gives code 12 with bank 0.
- R13: Only one rule is reported per cycle. A rule broken by a command outranks the open-too-long and refresh-late rules. For an activate the order is code 1, then 4, then 2, then 3. For a read or write the order is code 7, then 6, then 5, then 8. For a precharge the order is code 7, then 9. For an all-bank precharge, the lowest bank with a broken rule is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples commands |
| rst_n | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, low enables decoding |
| rasN | input | 1 | Row strobe level |
| casN | input | 1 | Column strobe level |
| weN | input | 1 | Write enable level |
| cke | input | 1 | Clock enable level |
| bankSel | input | BW | Bank select |
| a10 | input | 1 | Auto-close / all-bank address bit |
| violValid | output | 1 | One-cycle violation pulse |
| violRule | output | 4 | Rule code of the violation |
| violBank | output | BW | Bank the violation refers to |
| bankOpen | output | NB | Per-bank open state |

## Verification
The hardest situation to bring about is a command that lands exactly on the edge of an auto-close window. That window ends either when the auto-close burst is over or when its recovery time has passed. To reach it, the bench first activates a bank, then issues a read or write with `a10` high, then places the next read or activate at every gap from one cycle up to one cycle past the window. The expected rule code is computed from the gap. Every other timing limit is swept the same way, so each boundary is tested one cycle before it, on it, and one cycle after it. A second instance with full-page bursts covers the rule that is only legal in that configuration.

// File: rtl/sdram_timing_guard_pkg.sv
package sdram_timing_guard_pkg;

  typedef enum logic [3:0] {
    RULE_NONE     = 4'd0,
    RULE_ACT_OPEN = 4'd1,
    RULE_RC       = 4'd2,
    RULE_RRD      = 4'd3,
    RULE_RP       = 4'd4,
    RULE_RCD      = 4'd5,
    RULE_RW_IDLE  = 4'd6,
    RULE_AP_INT   = 4'd7,
    RULE_AP_FULL  = 4'd8,
    RULE_RAS_MIN  = 4'd9,
    RULE_RAS_MAX  = 4'd10,
    RULE_REF_BUSY = 4'd11,
    RULE_REF_LATE = 4'd12
  } rule_e;

  // Per-bank strobes from control to the state/counter datapath
  typedef struct packed {
    logic act;   // activate
    logic pre;   // explicit close of an open bank
    logic rw;    // read or write to an open bank
    logic ap;    // read or write with auto-close
  } bankStb_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_timing_guard_dp.sv
module sdram_timing_guard_dp
  import sdram_timing_guard_pkg::*;
#(
  parameter int NB        = 4,
  parameter int CW        = 8,
  parameter int BURST_LEN = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  bankStb_t [NB-1:0]      stb,
  input  logic                   refStb,
  output logic [NB-1:0]          bankOpen,
  output logic [NB-1:0]          apBusy,
  output logic [NB-1:0]          apLast,
  output logic [NB-1:0][CW-1:0]  sinceAct,
  output logic [NB-1:0][CW-1:0]  sinceClose,
  output logic [CW-1:0]          refCnt
);

  localparam logic [CW-1:0] CNT_SAT = '1;
  localparam logic [CW-1:0] BL_C    = CW'(BURST_LEN);

  function automatic logic [CW-1:0] satInc(input logic [CW-1:0] v);
    return (v == CNT_SAT) ? v : v + 1'b1;
  endfunction

  logic [NB-1:0]         apPend;
  logic [NB-1:0][CW-1:0] sinceRw;

  for (genvar i = 0; i < NB; i++) begin : gBank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bankOpen[i]   <= 1'b0;
        apPend[i]     <= 1'b0;
        apLast[i]     <= 1'b0;
        sinceAct[i]   <= CNT_SAT;
        sinceClose[i] <= CNT_SAT;
        sinceRw[i]    <= CNT_SAT;
      end else begin
        sinceAct[i]   <= stb[i].act ? CW'(1) : satInc(sinceAct[i]);
        sinceRw[i]    <= stb[i].rw  ? CW'(1) : satInc(sinceRw[i]);
        sinceClose[i] <= (stb[i].pre || stb[i].ap) ? CW'(1) : satInc(sinceClose[i]);
        if (stb[i].act)                     bankOpen[i] <= 1'b1;
        else if (stb[i].pre || stb[i].ap)   bankOpen[i] <= 1'b0;
        if (stb[i].ap)                      apPend[i] <= 1'b1;
        else if (stb[i].act)                apPend[i] <= 1'b0;
        else if (apPend[i] && sinceRw[i] >= BL_C) apPend[i] <= 1'b0;
        if (stb[i].ap)                      apLast[i] <= 1'b1;
        else if (stb[i].pre)                apLast[i] <= 1'b0;
      end
    end

    assign apBusy[i] = apPend[i] && (sinceRw[i] < BL_C);

    // R8: a bank in an auto-close burst is never reported open
    assert_ap_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      apPend[i] |-> !bankOpen[i]);

    // R7: a bank only becomes open through an activate strobe
    assert_open_by_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bankOpen[i]) |-> $past(stb[i].act));

    // R3: elapsed-cycle counters never read zero
    assert_cnt_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sinceAct[i] != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) refCnt <= '0;
    else        refCnt <= refStb ? CW'(1) : satInc(refCnt);
  end

endmodule

// File: rtl/sdram_timing_guard_ctrl.sv
module sdram_timing_guard_ctrl
  import sdram_timing_guard_pkg::*;
#(
  parameter int NB        = 4,
  parameter int BW        = 2,
  parameter int CW        = 8,
  parameter int T_RCD     = 2,
  parameter int T_RC      = 7,
  parameter int T_RRD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RAS_MIN = 4,
  parameter int T_RAS_MAX = 100,
  parameter int T_REFI    = 100,
  parameter int BURST_LEN = 4,
  parameter bit FULL_PAGE = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   csN,
  input  logic                   rasN,
  input  logic                   casN,
  input  logic                   weN,
  input  logic                   cke,
  input  logic [BW-1:0]          bankSel,
  input  logic                   a10,
  input  logic [NB-1:0]          bankOpen,
  input  logic [NB-1:0]          apBusy,
  input  logic [NB-1:0]          apLast,
  input  logic [NB-1:0][CW-1:0]  sinceAct,
  input  logic [NB-1:0][CW-1:0]  sinceClose,
  input  logic [CW-1:0]          refCnt,
  output bankStb_t [NB-1:0]      stb,
  output logic                   refStb,
  output logic                   violValid,
  output rule_e                  violRule,
  output logic [BW-1:0]          violBank
);

  localparam logic [CW-1:0] RCD_C  = CW'(T_RCD);
  localparam logic [CW-1:0] RC_C   = CW'(T_RC);
  localparam logic [CW-1:0] RRD_C  = CW'(T_RRD);
  localparam logic [CW-1:0] RP_C   = CW'(T_RP);
  localparam logic [CW-1:0] APRP_C = CW'(BURST_LEN + T_RP);
  localparam logic [CW-1:0] RMIN_C = CW'(T_RAS_MIN);
  localparam logic [CW-1:0] RMAX_C = CW'(T_RAS_MAX);
  localparam logic [CW-1:0] REFI_C = CW'(T_REFI);

  logic [2:0] pinCode;
  logic live, isAct, isPre, isRw, isRef;

  assign pinCode = {rasN, casN, weN};
  assign live    = !csN && cke;
  assign isAct   = live && pinCode == 3'b011;
  assign isPre   = live && pinCode == 3'b010;
  assign isRw    = live && (pinCode == 3'b101 || pinCode == 3'b100);
  assign isRef   = !csN && pinCode == 3'b001;
  assign refStb  = isRef;

  for (genvar i = 0; i < NB; i++) begin : gStb
    logic hit;
    assign hit        = (bankSel == BW'(i));
    assign stb[i].act = isAct && hit;
    assign stb[i].pre = isPre && (a10 || hit) && bankOpen[i];
    assign stb[i].rw  = isRw && hit && bankOpen[i];
    assign stb[i].ap  = isRw && hit && bankOpen[i] && a10;
  end

  rule_e         nextRule;
  logic [BW-1:0] nextBank;

  always_comb begin
    logic found;
    nextRule = RULE_NONE;
    nextBank = bankSel;
    found    = 1'b0;
    if (isAct) begin
      if (bankOpen[bankSel])
        nextRule = RULE_ACT_OPEN;
      else if (sinceClose[bankSel] < (apLast[bankSel] ? APRP_C : RP_C))
        nextRule = RULE_RP;
      else if (sinceAct[bankSel] < RC_C)
        nextRule = RULE_RC;
      else
        for (int i = 0; i < NB; i++)
          if (BW'(i) != bankSel && sinceAct[i] < RRD_C) nextRule = RULE_RRD;
    end else if (isRw) begin
      if (apBusy[bankSel])                 nextRule = RULE_AP_INT;
      else if (!bankOpen[bankSel])         nextRule = RULE_RW_IDLE;
      else if (sinceAct[bankSel] < RCD_C)  nextRule = RULE_RCD;
      else if (a10 && FULL_PAGE)           nextRule = RULE_AP_FULL;
    end else if (isPre) begin
      for (int i = 0; i < NB; i++) begin
        if (!found && (a10 || BW'(i) == bankSel)) begin
          if (apBusy[i]) begin
            nextRule = RULE_AP_INT;  nextBank = BW'(i); found = 1'b1;
          end else if (bankOpen[i] && sinceAct[i] < RMIN_C) begin
            nextRule = RULE_RAS_MIN; nextBank = BW'(i); found = 1'b1;
          end
        end
      end
    end else if (isRef) begin
      for (int i = 0; i < NB; i++)
        if (!found && (bankOpen[i] || apBusy[i])) begin
          nextRule = RULE_REF_BUSY; nextBank = BW'(i); found = 1'b1;
        end
    end
    if (nextRule == RULE_NONE) begin
      for (int i = 0; i < NB; i++)
        if (!found && bankOpen[i] && sinceAct[i] == RMAX_C) begin
          nextRule = RULE_RAS_MAX; nextBank = BW'(i); found = 1'b1;
        end
      if (!found && !isRef && refCnt == REFI_C) begin
        nextRule = RULE_REF_LATE; nextBank = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      violValid <= 1'b0;
      violRule  <= RULE_NONE;
      violBank  <= '0;
    end else begin
      violValid <= (nextRule != RULE_NONE);
      violRule  <= nextRule;
      violBank  <= nextBank;
    end
  end

  // R2: activate to an open bank is reported next cycle
  assert_act_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (isAct && bankOpen[bankSel]) |=> (violValid && violRule == RULE_ACT_OPEN));

  // R11: refresh while a bank is busy is reported next cycle
  assert_ref_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (isRef && |(bankOpen | apBusy)) |=> (violValid && violRule == RULE_REF_BUSY));

  // R6: early column access to an open bank is reported next cycle
  assert_rcd_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (isRw && bankOpen[bankSel] && !apBusy[bankSel] && sinceAct[bankSel] < RCD_C)
      |=> (violValid && violRule == RULE_RCD));

endmodule

// File: rtl/sdram_timing_guard.sv
module sdram_timing_guard
  import sdram_timing_guard_pkg::*;
#(
  parameter int NB        = 4,
  parameter int T_RCD     = 2,
  parameter int T_RC      = 7,
  parameter int T_RRD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RAS_MIN = 4,
  parameter int T_RAS_MAX = 10000,
  parameter int T_REFI    = 780,
  parameter int BURST_LEN = 4,
  parameter bit FULL_PAGE = 1'b0,
  localparam int BW       = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csN,
  input  logic          rasN,
  input  logic          casN,
  input  logic          weN,
  input  logic          cke,
  input  logic [BW-1:0] bankSel,
  input  logic          a10,
  output logic          violValid,
  output logic [3:0]    violRule,
  output logic [BW-1:0] violBank,
  output logic [NB-1:0] bankOpen
);

  localparam int MAXT = maxOf(maxOf(T_RAS_MAX, T_REFI),
                              maxOf(BURST_LEN + T_RP, maxOf(T_RC, T_RAS_MIN)));
  localparam int CW   = $clog2(MAXT + 2);

  bankStb_t [NB-1:0]     stb;
  logic                  refStb;
  logic [NB-1:0]         apBusy, apLast;
  logic [NB-1:0][CW-1:0] sinceAct, sinceClose;
  logic [CW-1:0]         refCnt;
  rule_e                 ruleQ;

  sdram_timing_guard_ctrl #(
    .NB(NB), .BW(BW), .CW(CW), .T_RCD(T_RCD), .T_RC(T_RC), .T_RRD(T_RRD),
    .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX),
    .T_REFI(T_REFI), .BURST_LEN(BURST_LEN), .FULL_PAGE(FULL_PAGE)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .bankSel(bankSel), .a10(a10), .bankOpen(bankOpen),
    .apBusy(apBusy), .apLast(apLast), .sinceAct(sinceAct),
    .sinceClose(sinceClose), .refCnt(refCnt), .stb(stb), .refStb(refStb),
    .violValid(violValid), .violRule(ruleQ), .violBank(violBank)
  );

  sdram_timing_guard_dp #(.NB(NB), .CW(CW), .BURST_LEN(BURST_LEN)) uDp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .refStb(refStb),
    .bankOpen(bankOpen), .apBusy(apBusy), .apLast(apLast),
    .sinceAct(sinceAct), .sinceClose(sinceClose), .refCnt(refCnt)
  );

  assign violRule = ruleQ;

endmodule

// File: tb/sim_sdram_timing_guard.sv
module sim_sdram_timing_guard;

  localparam int T_RCD = 2, T_RC = 8, T_RRD = 3, T_RP = 2;
  localparam int T_RAS_MIN = 3, T_RAS_MAX = 40, T_REFI = 200, BL = 4;
  localparam logic [2:0] C_ACT = 3'b011, C_PRE = 3'b010, C_RD = 3'b101;
  localparam logic [2:0] C_WR = 3'b100, C_REF = 3'b001, C_NOP = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, cke = 1'b1, a10 = 1'b0;
  logic [1:0] bankSel = '0;
  logic       violValid, fpValid;
  logic [3:0] violRule, fpRule;
  logic [1:0] violBank, fpBank;
  logic [3:0] bankOpen, fpOpen;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdram_timing_guard #(.T_RCD(T_RCD), .T_RC(T_RC), .T_RRD(T_RRD), .T_RP(T_RP),
    .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX), .T_REFI(T_REFI),
    .BURST_LEN(BL), .FULL_PAGE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .bankSel(bankSel), .a10(a10), .violValid(violValid),
    .violRule(violRule), .violBank(violBank), .bankOpen(bankOpen));

  sdram_timing_guard #(.T_RCD(T_RCD), .T_RC(T_RC), .T_RRD(T_RRD), .T_RP(T_RP),
    .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX), .T_REFI(T_REFI),
    .BURST_LEN(BL), .FULL_PAGE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .bankSel(bankSel), .a10(a10), .violValid(fpValid),
    .violRule(fpRule), .violBank(fpBank), .bankOpen(fpOpen));

  task automatic checkViol(input string tag, input int expRule, input int expBank);
    checks++;
    if (expRule == 0) begin
      if (violValid) begin
        errors++;
        $display("FAIL %s: valid=1 rule=%0d bank=%0d expected no violation",
                 tag, violRule, violBank);
      end
    end else if (!violValid || int'(violRule) != expRule || int'(violBank) != expBank) begin
      errors++;
      $display("FAIL %s: valid=%0b rule=%0d bank=%0d expected rule=%0d bank=%0d",
               tag, violValid, violRule, violBank, expRule, expBank);
    end
  endtask

  task automatic checkOpen(input string tag, input logic [3:0] exp);
    checks++;
    if (bankOpen !== exp) begin
      errors++;
      $display("FAIL %s: bankOpen=%b expected %b", tag, bankOpen, exp);
    end
  endtask

  task automatic issue(input logic [2:0] code, input int bank, input logic a10v,
                       input logic ckev, input int expRule, input int expBank,
                       input string tag);
    csN = 1'b0; {rasN, casN, weN} = code; bankSel = bank[1:0]; a10 = a10v; cke = ckev;
    @(posedge clk); @(negedge clk);
    csN = 1'b1; {rasN, casN, weN} = C_NOP; a10 = 1'b0; cke = 1'b1;
    checkViol(tag, expRule, expBank);
  endtask

  task automatic idle(input int n, input string tag);
    bit bad = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
      if (violValid) bad = 1'b1;
    end
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: violation during idle, last rule=%0d expected none", tag, violRule);
    end
  endtask

  task automatic cleanup();
    idle(8, "R13 idle");
    issue(C_PRE, 0, 1'b1, 1'b1, 0, 0, "R7 close all");
    idle(10, "R13 idle");
    issue(C_REF, 0, 1'b0, 1'b1, 0, 0, "R11 legal refresh");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    checkViol("R1 reset", 0, 0);
    checkOpen("R1 reset open", 4'b0000);
    cleanup();

    // R6: T_RCD sweep
    for (int g = 1; g <= T_RCD + 1; g++) begin
      issue(C_ACT, 0, 1'b0, 1'b1, 0, 0, "R6 act");
      if (g > 1) idle(g - 1, "R6 gap");
      issue(C_RD, 0, 1'b0, 1'b1, (g < T_RCD) ? 5 : 0, 0, "R6 rcd");
      cleanup();
    end

    // R3: T_RC sweep with precharge in between
    for (int g = 5; g <= T_RC + 1; g++) begin
      issue(C_ACT, 0, 1'b0, 1'b1, 0, 0, "R3 act");
      idle(2, "R3 gap");
      issue(C_PRE, 0, 1'b0, 1'b1, 0, 0, "R3 pre");
      if (g > 4) idle(g - 4, "R3 gap");
      issue(C_ACT, 0, 1'b0, 1'b1, (g < T_RC) ? 2 : 0, 0, "R3 rc");
      cleanup();
    end

    // R4: T_RRD sweep
    for (int g = 1; g <= T_RRD + 1; g++) begin
      issue(C_ACT, 0, 1'b0, 1'b1, 0, 0, "R4 act");
      if (g > 1) idle(g - 1, "R4 gap");
      issue(C_ACT, 1, 1'b0, 1'b1, (g < T_RRD) ? 3 : 0, 1, "R4 rrd");
      cleanup();
    end

    // R5: T_RP sweep after explicit precharge
    for (int g = 1; g <= T_RP + 1; g++) begin
      issue(C_ACT, 0, 1'b0, 1'b1, 0, 0, "R5 act");
      idle(9, "R5 gap");
      issue(C_PRE, 0, 1'b0, 1'b1, 0, 0, "R5 pre");
      if (g > 1) idle(g - 1, "R5 gap");
      issue(C_ACT, 0, 1'b0, 1'b1, (g < T_RP) ? 4 : 0, 0, "R5 rp");
      cleanup();
    end

    // R5/R8: recovery after auto-close read
    for (int g = 1; g <= BL + T_RP + 1; g++) begin
      issue(C_ACT, 0, 1'b0, 1'b1, 0, 0, "R5 act");
      idle(1, "R5 gap");
      issue(C_RD, 0, 1'b1, 1'b1, 0, 0, "R8 read auto-close");
      if (g > 1) idle(g - 1, "R5 gap");
      issue(C_ACT, 0, 1'b0, 1'b1, (g < BL + T_RP) ? 4 : 0, 0, "R5 ap recovery");
      cleanup();
    end

    // R8/R6: access during and after an auto-close write burst
    for (int g = 1; g <= BL + 1; g++) begin
      issue(C_ACT, 1, 1'b0, 1'b1, 0, 0, "R8 act");
      idle(1, "R8 gap");
      issue(C_WR, 1, 1'b1, 1'b1, 0, 0, "R8 write auto-close");
      if (g > 1) idle(g - 1, "R8 gap");
      issue(C_RD, 1, 1'b0, 1'b1, (g < BL) ? 7 : 6, 1, "R8 interrupt / R6 idle bank");
      cleanup();
    end
    issue(C_ACT, 2, 1'b0, 1'b1, 0, 0, "R8 act");
    idle(1, "R8 gap");
    issue(C_WR, 2, 1'b1, 1'b1, 0, 0, "R8 write auto-close");
    issue(C_PRE, 2, 1'b0, 1'b1, 7, 2, "R8 precharge in burst");
    cleanup();

    // R10: T_RAS_MIN sweep
    for (int g = 1; g <= T_RAS_MIN + 1; g++) begin
      issue(C_ACT, 2, 1'b0, 1'b1, 0, 0, "R10 act");
      if (g > 1) idle(g - 1, "R10 gap");
      issue(C_PRE, 2, 1'b0, 1'b1, (g < T_RAS_MIN) ? 9 : 0, 2, "R10 ras min");
      cleanup();
    end

    // R10: bank open too long
    issue(C_ACT, 2, 1'b0, 1'b1, 0, 0, "R10 act");
    idle(T_RAS_MAX - 1, "R10 quiet");
    @(posedge clk); @(negedge clk);
    checkViol("R10 ras max", 10, 2);
    idle(2, "R1 single pulse");
    cleanup();

    // R7: per-bank and all-bank precharge
    issue(C_ACT, 0, 1'b0, 1'b1, 0, 0, "R7 act0");
    idle(2, "R7 gap");
    issue(C_ACT, 3, 1'b0, 1'b1, 0, 0, "R7 act3");
    checkOpen("R7 two open", 4'b1001);
    idle(3, "R7 gap");
    issue(C_PRE, 0, 1'b0, 1'b1, 0, 0, "R7 pre one");
    checkOpen("R7 one closed", 4'b1000);
    issue(C_PRE, 1, 1'b1, 1'b1, 0, 0, "R7 pre all");
    checkOpen("R7 all closed", 4'b0000);
    cleanup();

    // R2/R13: activate to open bank, also inside T_RC: code 1 wins
    issue(C_ACT, 1, 1'b0, 1'b1, 0, 0, "R2 act");
    idle(1, "R2 gap");
    issue(C_ACT, 1, 1'b0, 1'b1, 1, 1, "R2 R13 act to open bank");
    cleanup();

    // R11: refresh with open bank, both forms
    issue(C_ACT, 3, 1'b0, 1'b1, 0, 0, "R11 act");
    idle(3, "R11 gap");
    issue(C_REF, 0, 1'b0, 1'b1, 11, 3, "R11 auto refresh busy");
    issue(C_REF, 0, 1'b0, 1'b0, 11, 3, "R11 self refresh busy");
    cleanup();

    // R9: full-page configuration rejects auto-close
    issue(C_ACT, 1, 1'b0, 1'b1, 0, 0, "R9 act");
    idle(2, "R9 gap");
    issue(C_WR, 1, 1'b1, 1'b1, 0, 0, "R9 legal on burst config");
    checks++;
    if (!fpValid || fpRule != 4'd8 || fpBank != 2'd1) begin
      errors++;
      $display("FAIL R9 full page: valid=%0b rule=%0d bank=%0d expected rule=8 bank=1",
               fpValid, fpRule, fpBank);
    end
    cleanup();

    // R12: refresh late
    idle(T_REFI - 1, "R12 quiet");
    @(posedge clk); @(negedge clk);
    checkViol("R12 refresh late", 12, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule